// File: doc/BRIEF.md
# Serial Flash Status-Register Write Handler

This block decodes the status-register write command of a serial flash slave. While the active-low select is held low, it shifts in a command byte and then one data byte from the serial input, sampling on rising serial-clock edges (SPI mode 0). The new state is committed only when select returns high. The command can change the sector-protection lock bit (`lockBit`). It always consumes the write-enable latch (`welOut`). Under some conditions it also protects or unprotects every entry of a per-sector protection vector at once.

The block runs on a system clock `clk`. The serial clock, select, serial data, write-protect and write-enable-set inputs are taken to be already synchronous to `clk`. Edges on `spiSck` and `spiCsN` are found by comparing each input with its value one `clk` earlier. A separate write-enable command in the wider decoder pulses `welSetIn` to arm the latch. The lock bit, latch and protection vector feed the rest of the flash as plain status outputs.

Top module: `flash_wrsr_top`

## Requirements
- R1: After the asynchronous active-low reset, `lockBit`, `welOut` and every bit of `sectorProt` are 0.
- R2: If `welOut` is 0 when select rises, a complete command changes neither `lockBit` nor `sectorProt`.
- R3: The command byte 0x01 and the data byte are both received most significant bit first. Bit 7 of the data byte is the new `lockBit` value. Bits 5 down to 2 form the global field. Bits 6, 1 and 0 have no effect.
- R4: Bits clocked in after the 16th bit of a frame have no effect on the result.
- R5: When select rises after a complete data byte with `welOut` at 1 and the write allowed, `lockBit` takes data bit 7 and `welOut` goes to 0 on the first `clk` edge that sees select high.
- R6: If select rises after the command byte 0x01 but before all 8 data bits have arrived, `lockBit` and `sectorProt` are unchanged and `welOut` is cleared.
- R7: If `wpN` is 0 at commit and data bit 7 is 0, the whole command is ignored (including any global operation) and `welOut` is still cleared.
- R8: A global operation runs only when `lockBit` was 0 before the command. Field 4'b1111 sets all `SECTORS` bits of `sectorProt`, 4'b0000 clears them all, and any other field leaves them unchanged.
- R9: A frame whose first 8 bits are not 0x01, or that ends before 8 bits, leaves `welOut`, `lockBit` and `sectorProt` unchanged.
- R10: A `clk`-cycle pulse on `welSetIn` sets `welOut` on the next edge. If it coincides with a commit that clears the latch, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every other input |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSck | input | 1 | Serial clock; data sampled on its rising edge |
| spiCsN | input | 1 | Active-low select framing one command |
| spiSi | input | 1 | Serial data input, MSB first |
| wpN | input | 1 | Active-low write-protect pin |
| welSetIn | input | 1 | One-cycle pulse from the write-enable command |
| lockBit | output | 1 | Sector-protection lock bit |
| welOut | output | 1 | Write-enable latch |
| sectorProt | output | SECTORS | Per-sector protection vector |

## Verification
Every result of a frame is due on the first `clk` edge that sees select high. The frame decode and the status registers sit behind one register stage from the select edge. A `welSetIn` pulse shows on `welOut` one edge after it is seen. The bench drives inputs on falling `clk` edges. It holds select high for three cycles before it reads all three outputs on a falling edge, so the result has settled well after the one-edge latency. The expected values come from a bench function that applies the frame rules to the bench's own copy of the prior state.

// File: rtl/flash_wrsr_pkg.sv
package flash_wrsr_pkg;

  localparam int BYTE_BITS = 8;
  localparam int FRAME_BITS = 2 * BYTE_BITS;
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  // Field positions inside the data byte
  localparam int LOCK_POS = 7;
  localparam int GLOB_HI = 5;
  localparam int GLOB_LO = 2;
  localparam int GLOB_W = GLOB_HI - GLOB_LO + 1;

  typedef struct packed {
    logic welClear;
    logic lockLoad;
    logic lockValue;
    logic protAll;
    logic unprotAll;
  } ctrlStrobe_t;

endpackage

// File: rtl/wrsr_frame_ctrl.sv
module wrsr_frame_ctrl
  import flash_wrsr_pkg::*;
#(
  parameter logic [BYTE_BITS-1:0] OPCODE = 8'h01
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        spiSck,
  input  logic        spiCsN,
  input  logic        spiSi,
  input  logic        wpN,
  input  logic        lockNow,
  input  logic        welNow,
  output ctrlStrobe_t strobe
);

  logic sckPrev;
  logic csPrev;
  logic [CNT_W-1:0] bitCount;
  logic [BYTE_BITS-1:0] shiftReg;
  logic [BYTE_BITS-1:0] dataByte;
  logic opcodeOk;

  logic sckRise;
  logic csRise;
  logic frameOpen;
  logic [BYTE_BITS-1:0] shiftNext;

  assign frameOpen = (bitCount < CNT_W'(FRAME_BITS));
  assign sckRise = spiSck & ~sckPrev & ~spiCsN;
  assign csRise = spiCsN & ~csPrev;
  assign shiftNext = {shiftReg[BYTE_BITS-2:0], spiSi};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      csPrev <= 1'b1;
    end else begin
      sckPrev <= spiSck;
      csPrev <= spiCsN;
    end
  end

  // Bit counter and shifter, cleared whenever select is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
      shiftReg <= '0;
      dataByte <= '0;
      opcodeOk <= 1'b0;
    end else if (spiCsN) begin
      bitCount <= '0;
      opcodeOk <= 1'b0;
    end else if (sckRise && frameOpen) begin
      shiftReg <= shiftNext;
      bitCount <= bitCount + CNT_W'(1);
      if (bitCount == CNT_W'(BYTE_BITS - 1)) begin
        opcodeOk <= (shiftNext == OPCODE);
      end
      if (bitCount == CNT_W'(FRAME_BITS - 1)) begin
        dataByte <= shiftNext;
      end
    end
  end

  logic opcodeSeen;
  logic dataDone;
  logic wpBlocks;
  logic [GLOB_W-1:0] globField;

  assign opcodeSeen = opcodeOk && (bitCount >= CNT_W'(BYTE_BITS));
  assign dataDone = (bitCount == CNT_W'(FRAME_BITS));
  assign wpBlocks = ~wpN & ~dataByte[LOCK_POS];
  assign globField = dataByte[GLOB_HI:GLOB_LO];

  always_comb begin
    strobe = '0;
    if (csRise && opcodeSeen) begin
      strobe.welClear = 1'b1;
      if (dataDone && welNow && !wpBlocks) begin
        strobe.lockLoad = 1'b1;
        strobe.lockValue = dataByte[LOCK_POS];
        if (!lockNow) begin
          strobe.protAll = (globField == '1);
          strobe.unprotAll = (globField == '0);
        end
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= CNT_W'(FRAME_BITS)); // R4
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |=> (bitCount == '0)); // R9
  AST_GLOBAL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.protAll, strobe.unprotAll})); // R8
  AST_LOAD_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lockLoad |-> welNow); // R2

endmodule

// File: rtl/wrsr_status_regs.sv
module wrsr_status_regs
  import flash_wrsr_pkg::*;
#(
  parameter int SECTORS = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic               welSetIn,
  input  logic               wpN,
  output logic               lockBit,
  output logic               welOut,
  output logic [SECTORS-1:0] sectorProt
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockBit <= 1'b0;
    end else if (strobe.lockLoad) begin
      lockBit <= strobe.lockValue;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welOut <= 1'b0;
    end else if (strobe.welClear) begin
      welOut <= 1'b0;
    end else if (welSetIn) begin
      welOut <= 1'b1;
    end
  end

  for (genvar s = 0; s < SECTORS; s++) begin : gSector
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sectorProt[s] <= 1'b0;
      end else if (strobe.protAll) begin
        sectorProt[s] <= 1'b1;
      end else if (strobe.unprotAll) begin
        sectorProt[s] <= 1'b0;
      end
    end
  end

  AST_WEL_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.welClear |=> !welOut); // R5
  AST_WEL_SET: assert property (@(posedge clk) disable iff (!rstN)
    (welSetIn && !strobe.welClear) |=> welOut); // R10
  AST_WP_HOLDS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (!wpN && lockBit) |=> lockBit); // R7
  AST_LOCK_FREEZES_VEC: assert property (@(posedge clk) disable iff (!rstN)
    lockBit |=> $stable(sectorProt)); // R8
  AST_NO_WEL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    !welOut |=> ($stable(lockBit) && $stable(sectorProt))); // R2

endmodule

// File: rtl/flash_wrsr_top.sv
module flash_wrsr_top
  import flash_wrsr_pkg::*;
#(
  parameter int SECTORS = 16,
  parameter logic [7:0] OPCODE = 8'h01
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               spiSck,
  input  logic               spiCsN,
  input  logic               spiSi,
  input  logic               wpN,
  input  logic               welSetIn,
  output logic               lockBit,
  output logic               welOut,
  output logic [SECTORS-1:0] sectorProt
);

  ctrlStrobe_t strobe;

  wrsr_frame_ctrl #(
    .OPCODE(OPCODE)
  ) ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .spiSck(spiSck),
    .spiCsN(spiCsN),
    .spiSi(spiSi),
    .wpN(wpN),
    .lockNow(lockBit),
    .welNow(welOut),
    .strobe(strobe)
  );

  wrsr_status_regs #(
    .SECTORS(SECTORS)
  ) regs_i (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .welSetIn(welSetIn),
    .wpN(wpN),
    .lockBit(lockBit),
    .welOut(welOut),
    .sectorProt(sectorProt)
  );

endmodule

// File: tb/flash_wrsr_top_tb_top.sv
module flash_wrsr_top_tb_top;

  localparam int SECTORS = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSck = 1'b0;
  logic spiCsN = 1'b1;
  logic spiSi = 1'b0;
  logic wpN = 1'b1;
  logic welSetIn = 1'b0;
  logic lockBit;
  logic welOut;
  logic [SECTORS-1:0] sectorProt;

  int vecCount = 0;
  int errCount = 0;
  int cycles = 0;
  bit done = 0;

  logic expLock = 1'b0;
  logic expWel = 1'b0;
  logic [SECTORS-1:0] expVec = '0;

  always #5 clk = ~clk;

  flash_wrsr_top #(.SECTORS(SECTORS)) dut_i (
    .clk(clk), .rstN(rstN), .spiSck(spiSck), .spiCsN(spiCsN),
    .spiSi(spiSi), .wpN(wpN), .welSetIn(welSetIn),
    .lockBit(lockBit), .welOut(welOut), .sectorProt(sectorProt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check({tag, " lock"}, 32'(lockBit), 32'(expLock));
    check({tag, " wel"}, 32'(welOut), 32'(expWel));
    check({tag, " vec"}, 32'(sectorProt), 32'(expVec));
  endtask

  // Bench model of one frame (R2..R9)
  function automatic void modelFrame(input logic [7:0] op, input logic [7:0] data,
                                     input int nbits, input logic wp);
    if (nbits < 8 || op != 8'h01) return;             // R9
    if (nbits < 16) begin expWel = 1'b0; return; end   // R6
    if (!expWel) return;                               // R2
    expWel = 1'b0;
    if (!wp && !data[7]) return;                       // R7
    if (!expLock) begin                                // R8
      if (data[5:2] == 4'hF) expVec = '1;
      else if (data[5:2] == 4'h0) expVec = '0;
    end
    expLock = data[7];                                 // R3 R5
  endfunction

  task automatic pulseWel();
    @(negedge clk) welSetIn = 1'b1;
    @(negedge clk) welSetIn = 1'b0;
    expWel = 1'b1;
    @(negedge clk);
    check("R10 wel set", 32'(welOut), 32'(1));
  endtask

  task automatic sendFrame(input logic [31:0] bits, input int nbits, input logic wp,
                           input bit welAtEdge, input string tag);
    @(negedge clk) spiCsN = 1'b0; wpN = wp;
    repeat (2) @(negedge clk);
    for (int i = 31; i > 31 - nbits; i--) begin
      spiSck = 1'b0; spiSi = bits[i];
      repeat (2) @(negedge clk);
      spiSck = 1'b1;
      repeat (2) @(negedge clk);
    end
    spiSck = 1'b0;
    repeat (2) @(negedge clk);
    spiCsN = 1'b1; welSetIn = welAtEdge;
    @(negedge clk) welSetIn = 1'b0;
    modelFrame(bits[31:24], bits[23:16], nbits, wp);
    repeat (2) @(negedge clk);
    checkAll(tag);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errCount++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20517));
    repeat (3) @(negedge clk);
    checkAll("R1 reset");
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2: no WEL, lock write has no effect
    sendFrame({8'h01, 8'h80, 16'h0}, 16, 1'b1, 1'b0, "R2 no wel");
    // R3 R8: global protect with prior lock 0, set lock
    pulseWel();
    sendFrame({8'h01, 8'hBC, 16'h0}, 16, 1'b1, 1'b0, "R3 R8 protect");
    // R8: prior lock 1, unprotect blocked, lock cleared
    pulseWel();
    sendFrame({8'h01, 8'h00, 16'h0}, 16, 1'b1, 1'b0, "R8 locked");
    // R8: unprotect now allowed
    pulseWel();
    sendFrame({8'h01, 8'h43, 16'h0}, 16, 1'b1, 1'b0, "R8 unprotect");
    // R4: extra bytes after data ignored
    pulseWel();
    sendFrame({8'h01, 8'h3C, 16'h00FF}, 32, 1'b1, 1'b0, "R4 extra");
    // R7: WP asserted, clear request ignored
    pulseWel();
    sendFrame({8'h01, 8'h80, 16'h0}, 16, 1'b1, 1'b0, "R5 set lock");
    pulseWel();
    sendFrame({8'h01, 8'h00, 16'h0}, 16, 1'b0, 1'b0, "R7 wp blocks");
    // R6: abort mid data byte
    pulseWel();
    sendFrame({8'h01, 8'h00, 16'h0}, 12, 1'b1, 1'b0, "R6 abort");
    // R9: wrong opcode and short frame keep WEL
    pulseWel();
    sendFrame({8'h02, 8'h00, 16'h0}, 16, 1'b1, 1'b0, "R9 bad op");
    sendFrame({8'h01, 8'h00, 16'h0}, 5, 1'b1, 1'b0, "R9 short");
    // R10: set pulse coincident with commit clear, clear wins
    sendFrame({8'h01, 8'h00, 16'h0}, 16, 1'b1, 1'b1, "R10 clear wins");

    for (int n = 0; n < 250; n++) begin
      logic [31:0] bits;
      int nb;
      int pick;
      bits = $urandom;
      if ($urandom_range(0, 9) < 8) bits[31:24] = 8'h01;
      pick = $urandom_range(0, 6);
      nb = (pick == 0) ? 4 : (pick == 1) ? 8 : (pick == 2) ? 12 :
           (pick == 6) ? 24 : 16;
      if ($urandom_range(0, 3) != 0) begin
        if ($urandom_range(0, 1) == 0) bits[21:18] = 4'hF;
        else bits[21:18] = 4'h0;
      end
      if ($urandom_range(0, 9) < 7) pulseWel();
      sendFrame(bits, nb, 1'($urandom_range(0, 1)), 1'b0, "R5 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule